// File: doc/BRIEF.md
# Byte-Wide Flash Programming Sequencer

This controller takes a byte-wide, electrically erasable flash with a classic EPROM pinout through one complete job. The job has three parts: a chip erase, a blank check, and a timed programming pass over every location. A read-back pass then compares each location with the image. The controller drives the address bus, the active-low chip-enable and output-enable strobes, and two enables for an external high-voltage supply. One enable lifts the shared output-enable/programming-voltage pin to about 12 V. The other lifts address line 9 to about 12 V for the erase. The controller also owns the direction of the bidirectional data bus. A host pulses `start`, then streams the image twice over a valid/ready handshake: once for programming and once for the compare. The host collects `done`, `pass` and the first failing address. Every pulse and recovery length is a clock-cycle count derived from the clock-frequency parameter, and one down-counter times all of them.

The address width is a parameter. The depth is 2**ADDR_W bytes, and products use 16, 17 or 18 bits (64K, 128K or 256K bytes). Data is read only while both strobes are low with the high voltage off. The controller drives the bus only while a programming pulse is in progress.

States and transitions:
- IDLE goes to ER_SETUP on `start`.
- ER_SETUP: both high-voltage enables are on for SETUP_CYC cycles. It then goes to ER_PULSE.
- ER_PULSE: chip enable is low for ERASE_CYC cycles. It then goes to ER_RECOV.
- ER_RECOV: both high-voltage enables are off for RECOV_CYC cycles. It then goes to BC_TURN.
- BC_TURN: one cycle with both strobes high. It then goes to BC_READ.
- BC_READ: both strobes are low for READ_CYC cycles. On a mismatch it goes to FIN. If this was the last address it goes to PG_SETUP. Otherwise the address increments and it returns to BC_TURN.
- PG_SETUP: the programming voltage is on for SETUP_CYC cycles. It then goes to PG_WAIT.
- PG_WAIT: waits for a handshake and then goes to PG_PULSE.
- PG_PULSE: chip enable is low and the data bus is driven for PROG_CYC cycles. If this was the last address it goes to PG_RECOV. Otherwise the address increments and it returns to PG_WAIT.
- PG_RECOV: the programming voltage is off for RECOV_CYC cycles. It then goes to VF_WAIT.
- VF_WAIT: waits for a handshake and then goes to VF_READ.
- VF_READ: both strobes are low for READ_CYC cycles. On a mismatch, or after the last address, it goes to FIN. Otherwise the address increments and it returns to VF_WAIT.
- FIN: one cycle, then back to IDLE.

Top module: `flash_prog_seq`

## Requirements
- R1: `start` in IDLE begins an erase: `vpp_en` and `a9_hv_en` rise together with `flash_ce_n` high for SETUP_CYC cycles, then `flash_ce_n` is low for exactly ERASE_CYC cycles; `start` while `busy` is ignored and yields no second `done`.
- R2: After the erase pulse both high-voltage enables stay low for at least RECOV_CYC cycles before the first read, and no read (both strobes low) ever occurs with `vpp_en` high.
- R3: The blank check reads addresses 0 to 2**ADDR_W-1 in ascending order; a byte other than FFh ends the job with `pass`=0, `fail_addr` set to that address, and no program pulse issued.
- R4: Programming visits addresses in ascending order from 0; each byte gets one pulse with `flash_ce_n` low for exactly PROG_CYC cycles, `vpp_en` high and `dq_out` holding the byte taken in the handshake for that address, with address and data steady through the pulse.
- R5: `src_ready` is high only while the sequencer waits for a byte; during a stall `flash_ce_n` stays high and no pulse starts until `src_valid` and `src_ready` are both high at a clock edge.
- R6: `dq_oe` is high only during a program pulse (chip enable low, output-enable pin high, `vpp_en` high), and it is low in the cycle before `flash_oe_n` falls.
- R7: After the last program pulse `vpp_en` stays low for at least RECOV_CYC cycles before the first verify read.
- R8: The verify pass takes the image a second time and compares each read-back byte with the byte streamed for that address; the first mismatch ends the job with `pass`=0 and `fail_addr` set to that address.
- R9: `done` is a one-cycle pulse issued with both high-voltage enables low; `pass` is 1 only when every verify byte matched; `pass` and `fail_addr` hold until the next accepted `start`.
- R10: `a9_hv_en` is high only together with `vpp_en`, and only in the erase phase.
- R11: After reset and in IDLE, `busy`, `done`, `vpp_en`, `a9_hv_en`, `dq_oe` and `src_ready` are 0 and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (accepted in IDLE only) |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| pass | output | 1 | Last job verified without error |
| fail_addr | output | ADDR_W | First failing address of the last job |
| src_valid | input | 1 | Image byte present |
| src_ready | output | 1 | Sequencer takes an image byte |
| src_data | input | 8 | Image byte |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| vpp_en | output | 1 | Lift output-enable pin to programming voltage |
| a9_hv_en | output | 1 | Lift address line 9 to high voltage for erase |
| dq_out | output | 8 | Data driven to the flash |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 8 | Data read from the flash |

## Verification
The bench models the flash array at the pins. A corrupted state register or counter shows within one pulse as a wrong erase or program width, a pulse at the wrong address or with the wrong byte, or bus drive overlapping a read. A wrong compare path shows at the end of the job as a wrong `pass` or `fail_addr`. A broken stall or recovery path shows in the first cycle that it happens, as chip enable low while the sequencer waits, or as a read too soon after the programming voltage drops. Faults injected at a single address check that the job stops exactly at the first bad byte.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ER_SETUP,
        S_ER_PULSE,
        S_ER_RECOV,
        S_BC_TURN,
        S_BC_READ,
        S_PG_SETUP,
        S_PG_WAIT,
        S_PG_PULSE,
        S_PG_RECOV,
        S_VF_WAIT,
        S_VF_READ,
        S_FIN
    } fps_state_e;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fps_addr_gen.sv
module fps_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clr) begin
            addr_q <= '0;
        end else if (inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (addr_q == {ADDR_W{1'b1}});
endmodule

// File: rtl/fps_fsm.sv
module fps_fsm
    import fps_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 8,
    parameter int SETUP_CYC = 2,
    parameter int ERASE_CYC = 2,
    parameter int PROG_CYC  = 2,
    parameter int RECOV_CYC = 2,
    parameter int READ_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    input  logic [7:0]        dq_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_last,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              addr_clr,
    output logic              addr_inc,
    output logic              src_ready,
    output logic              ce_n,
    output logic              oe_n,
    output logic              vpp_en,
    output logic              a9_hv_en,
    output logic              dq_oe,
    output logic [7:0]        dq_out,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam logic [CNT_W-1:0] T_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] T_ERASE = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] T_PROG  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] T_RECOV = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] T_READ  = CNT_W'(READ_CYC - 1);

    fps_state_e state_q, state_d;
    logic [7:0] byte_q;
    logic       pass_q;
    logic [ADDR_W-1:0] fail_q;
    logic       take;
    logic       mismatch;
    logic [7:0] expect_byte;

    assign take        = src_valid && src_ready;
    assign expect_byte = (state_q == S_BC_READ) ? BLANK_BYTE : byte_q;
    assign mismatch    = (dq_in != expect_byte);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state, counter load and address control
    always_comb begin
        state_d  = state_q;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d  = S_ER_SETUP;
                    addr_clr = 1'b1;
                end
            end
            S_ER_SETUP: if (tmr_zero) state_d = S_ER_PULSE;
            S_ER_PULSE: if (tmr_zero) state_d = S_ER_RECOV;
            S_ER_RECOV: if (tmr_zero) state_d = S_BC_TURN;
            S_BC_TURN:  state_d = S_BC_READ;
            S_BC_READ: begin
                if (tmr_zero) begin
                    if (mismatch) begin
                        state_d = S_FIN;
                    end else if (addr_last) begin
                        state_d  = S_PG_SETUP;
                        addr_clr = 1'b1;
                    end else begin
                        state_d  = S_BC_TURN;
                        addr_inc = 1'b1;
                    end
                end
            end
            S_PG_SETUP: if (tmr_zero) state_d = S_PG_WAIT;
            S_PG_WAIT:  if (take) state_d = S_PG_PULSE;
            S_PG_PULSE: begin
                if (tmr_zero) begin
                    if (addr_last) begin
                        state_d  = S_PG_RECOV;
                        addr_clr = 1'b1;
                    end else begin
                        state_d  = S_PG_WAIT;
                        addr_inc = 1'b1;
                    end
                end
            end
            S_PG_RECOV: if (tmr_zero) state_d = S_VF_WAIT;
            S_VF_WAIT:  if (take) state_d = S_VF_READ;
            S_VF_READ: begin
                if (tmr_zero) begin
                    if (mismatch || addr_last) begin
                        state_d = S_FIN;
                    end else begin
                        state_d  = S_VF_WAIT;
                        addr_inc = 1'b1;
                    end
                end
            end
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            S_ER_SETUP, S_PG_SETUP: tmr_val = T_SETUP;
            S_ER_PULSE:             tmr_val = T_ERASE;
            S_PG_PULSE:             tmr_val = T_PROG;
            S_ER_RECOV, S_PG_RECOV: tmr_val = T_RECOV;
            S_BC_READ, S_VF_READ:   tmr_val = T_READ;
            default:                tmr_val = '0;
        endcase
    end

    // captured image byte and job result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            pass_q <= 1'b0;
            fail_q <= '0;
        end else begin
            if (take) begin
                byte_q <= src_data;
            end
            if (state_q == S_IDLE && start) begin
                pass_q <= 1'b0;
                fail_q <= '0;
            end else if ((state_q == S_BC_READ || state_q == S_VF_READ) && tmr_zero) begin
                if (mismatch) begin
                    fail_q <= addr;
                end else if (state_q == S_VF_READ && addr_last) begin
                    pass_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        ce_n      = 1'b1;
        oe_n      = 1'b1;
        vpp_en    = 1'b0;
        a9_hv_en  = 1'b0;
        dq_oe     = 1'b0;
        src_ready = 1'b0;
        unique case (state_q)
            S_ER_SETUP: begin
                vpp_en   = 1'b1;
                a9_hv_en = 1'b1;
            end
            S_ER_PULSE: begin
                vpp_en   = 1'b1;
                a9_hv_en = 1'b1;
                ce_n     = 1'b0;
            end
            S_BC_READ, S_VF_READ: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
            end
            S_PG_SETUP: vpp_en = 1'b1;
            S_PG_WAIT: begin
                vpp_en    = 1'b1;
                src_ready = 1'b1;
            end
            S_PG_PULSE: begin
                vpp_en = 1'b1;
                ce_n   = 1'b0;
                dq_oe  = 1'b1;
            end
            S_VF_WAIT: src_ready = 1'b1;
            default: begin
                ce_n = 1'b1;
            end
        endcase
    end

    assign dq_out    = byte_q;
    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_FIN);
    assign pass      = pass_q;
    assign fail_addr = fail_q;
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
    parameter int ADDR_W    = 16,
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETUP_CYC = CLK_HZ / 1_000_000 + 1,
    parameter int ERASE_CYC = CLK_HZ / 10,
    parameter int PROG_CYC  = CLK_HZ / 50_000,
    parameter int RECOV_CYC = CLK_HZ / 1_000_000 + 1,
    parameter int READ_CYC  = CLK_HZ / 20_000_000 + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [7:0]        src_data,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              vpp_en,
    output logic              a9_hv_en,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    input  logic [7:0]        dq_in
);
    localparam int MAX_A   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_B   = (RECOV_CYC > SETUP_CYC) ? RECOV_CYC : SETUP_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_C > READ_CYC) ? MAX_C : READ_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             addr_clr;
    logic             addr_inc;
    logic             addr_last;

    fps_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    fps_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .inc   (addr_inc),
        .addr  (flash_addr),
        .last  (addr_last)
    );

    fps_fsm #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC),
        .RECOV_CYC (RECOV_CYC),
        .READ_CYC  (READ_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_valid (src_valid),
        .src_data  (src_data),
        .dq_in     (dq_in),
        .addr      (flash_addr),
        .addr_last (addr_last),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .addr_clr  (addr_clr),
        .addr_inc  (addr_inc),
        .src_ready (src_ready),
        .ce_n      (flash_ce_n),
        .oe_n      (flash_oe_n),
        .vpp_en    (vpp_en),
        .a9_hv_en  (a9_hv_en),
        .dq_oe     (dq_oe),
        .dq_out    (dq_out),
        .busy      (busy),
        .done      (done),
        .pass      (pass),
        .fail_addr (fail_addr)
    );
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              src_ready,
    input logic [ADDR_W-1:0] flash_addr,
    input logic              flash_ce_n,
    input logic              flash_oe_n,
    input logic              vpp_en,
    input logic              a9_hv_en,
    input logic [7:0]        dq_out,
    input logic              dq_oe
);
    assert_a9_with_vpp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        a9_hv_en |-> vpp_en);

    assert_drive_in_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!flash_ce_n && flash_oe_n && vpp_en && !a9_hv_en));

    assert_release_before_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_oe_n) |-> !$past(dq_oe));

    assert_read_low_voltage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> (!vpp_en && !a9_hv_en && !dq_oe));

    assert_stall_holds_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> flash_ce_n);

    assert_done_hv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!vpp_en && !a9_hv_en));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_pulse_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> ($stable(dq_out) && $stable(flash_addr)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flash_ce_n && flash_oe_n && !vpp_en && !dq_oe && !src_ready));
endmodule

bind flash_prog_seq fps_checker #(.ADDR_W(ADDR_W)) u_fps_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .src_ready  (src_ready),
    .flash_addr (flash_addr),
    .flash_ce_n (flash_ce_n),
    .flash_oe_n (flash_oe_n),
    .vpp_en     (vpp_en),
    .a9_hv_en   (a9_hv_en),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
);

// File: tb/tb_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_flash_prog_seq;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int SETUP = 3;
    localparam int ERASE = 40;
    localparam int PROG  = 6;
    localparam int RECOV = 5;
    localparam int READ  = 2;
    localparam int WDOG  = 20000;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, pass;
    logic [AW-1:0] fail_addr;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [7:0]    src_data = 8'h00;
    logic [AW-1:0] flash_addr;
    logic          flash_ce_n, flash_oe_n, vpp_en, a9_hv_en, dq_oe;
    logic [7:0]    dq_out, dq_in;

    always #2.5 clk = ~clk;

    flash_prog_seq #(
        .ADDR_W(AW), .CLK_HZ(200_000_000), .SETUP_CYC(SETUP), .ERASE_CYC(ERASE),
        .PROG_CYC(PROG), .RECOV_CYC(RECOV), .READ_CYC(READ)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail_addr(fail_addr), .src_valid(src_valid),
        .src_ready(src_ready), .src_data(src_data), .flash_addr(flash_addr),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .vpp_en(vpp_en),
        .a9_hv_en(a9_hv_en), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash array model
    logic [7:0] mem [DEPTH];
    int         fault_mode = 0;   // 0 none, 1 stuck byte after erase, 2 bad write
    int         fault_addr = 0;
    item_t      sb_q [$];
    int         er_len = 0, pg_len = 0, off_cnt = 0;
    bit         er_prev = 0, pg_prev = 0;
    logic [AW-1:0] pg_addr = '0;
    logic [7:0] pg_data = '0;
    int         n_prog = 0, recov_viol = 0, stall_viol = 0, done_cnt = 0;
    bit         seen_done = 0;
    int         last_rd = -1;
    int         order_viol = 0;

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    end

    assign dq_in = (!flash_ce_n && !flash_oe_n && !vpp_en) ? mem[flash_addr] : 8'hFF;

    // monitor: pin-level model and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            bit er_on, pg_on;
            er_on = !flash_ce_n && a9_hv_en && vpp_en;
            pg_on = !flash_ce_n && vpp_en && !a9_hv_en && dq_oe;
            if (er_on) begin
                er_len++;
            end else if (er_prev) begin
                chk(er_len == ERASE, "R1 erase pulse width", er_len, ERASE);
                for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
                if (fault_mode == 1) mem[fault_addr] = 8'hFE;
                er_len = 0;
                last_rd = -1;
            end
            er_prev = er_on;

            if (pg_on) begin
                pg_len++;
                pg_addr = flash_addr;
                pg_data = dq_out;
            end else if (pg_prev) begin
                chk(pg_len == PROG, "R4 program pulse width", pg_len, PROG);
                mem[pg_addr] = (fault_mode == 2 && int'(pg_addr) == fault_addr)
                               ? (pg_data ^ 8'h10) : pg_data;
                n_prog++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected program pulse", int'(pg_addr), -1);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(pg_addr == it.a, "R4 program address", int'(pg_addr), int'(it.a));
                    chk(pg_data == it.d, "R4 program data", int'(pg_data), int'(it.d));
                end
                pg_len = 0;
                last_rd = -1;
            end
            pg_prev = pg_on;

            if (vpp_en || a9_hv_en) off_cnt = 0;
            else off_cnt++;
            if (!flash_ce_n && !flash_oe_n) begin
                if (off_cnt < RECOV + 1) recov_viol++;
                if (int'(flash_addr) < last_rd) order_viol++;
                last_rd = int'(flash_addr);
            end
            if (src_ready && !flash_ce_n) stall_viol++;
            if (done) begin
                done_cnt++;
                seen_done = 1;
            end
        end
    end

    // driver
    logic [7:0] image [DEPTH];

    task automatic run_job(input int mode, input int faddr, input int stall,
                           input int src_bad, input bit exp_pass, input int exp_fail,
                           input int salt, input bit extra_start);
        int dc0, exp_prog;
        fault_mode = mode;
        fault_addr = faddr;
        for (int i = 0; i < DEPTH; i++) image[i] = 8'(i * 7 + 3 + salt);
        sb_q.delete();
        if (mode != 1) begin
            for (int i = 0; i < DEPTH; i++) sb_q.push_back({AW'(i), image[i]});
        end
        exp_prog = (mode == 1) ? 0 : DEPTH;
        n_prog = 0; recov_viol = 0; stall_viol = 0; order_viol = 0;
        seen_done = 0;
        dc0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (seen_done) break;
                if (stall != 0 && (i % 3) == 1) repeat (stall) @(negedge clk);
                if (extra_start && p == 0 && i == 4) begin
                    start = 1'b1;
                    @(negedge clk) start = 1'b0;
                end
                src_valid = 1'b1;
                src_data  = (p == 1 && i == src_bad) ? (image[i] ^ 8'h01) : image[i];
                while (!src_ready && !seen_done) @(negedge clk);
                @(negedge clk);
                src_valid = 1'b0;
            end
            if (seen_done) break;
        end
        while (!seen_done) @(negedge clk);
        @(negedge clk);
        chk(done_cnt - dc0 == 1, "R1/R9 one done per job", done_cnt - dc0, 1);
        chk(busy == 1'b0, "R9 idle after done", int'(busy), 0);
        chk(pass == exp_pass, "R9 pass result", int'(pass), int'(exp_pass));
        if (!exp_pass) begin
            if (mode == 1) chk(int'(fail_addr) == exp_fail, "R3 blank fail address", int'(fail_addr), exp_fail);
            else chk(int'(fail_addr) == exp_fail, "R8 verify fail address", int'(fail_addr), exp_fail);
        end
        if (mode == 1) chk(n_prog == 0, "R3 no pulse after blank fail", n_prog, 0);
        else chk(n_prog == exp_prog, "R4 pulse count", n_prog, exp_prog);
        chk(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);
        chk(recov_viol == 0, "R2/R7 recovery before read", recov_viol, 0);
        chk(stall_viol == 0, "R5 chip enable high while waiting", stall_viol, 0);
        chk(order_viol == 0, "R3/R8 ascending read order", order_viol, 0);
        repeat (5) @(negedge clk);
        chk(pass == exp_pass, "R9 pass held", int'(pass), int'(exp_pass));
        chk(done == 1'b0 && vpp_en == 1'b0 && a9_hv_en == 1'b0, "R10/R11 quiet after job",
            int'({done, vpp_en, a9_hv_en}), 0);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 0 && done == 0, "R11 reset busy/done", int'({busy, done}), 0);
        chk(flash_ce_n == 1 && flash_oe_n == 1, "R11 reset strobes", int'({flash_ce_n, flash_oe_n}), 3);
        chk(vpp_en == 0 && a9_hv_en == 0, "R11 reset high voltage", int'({vpp_en, a9_hv_en}), 0);
        chk(dq_oe == 0 && src_ready == 0, "R11 reset bus", int'({dq_oe, src_ready}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && pass == 0, "R11 idle after reset", int'({busy, pass}), 0);

        // R1 erase start, extra start ignored; R4/R8/R9 clean job
        run_job(0, 0, 0, -1, 1'b1, 0, 0, 1'b1);
        // R5 stalled source
        run_job(0, 0, 2, -1, 1'b1, 0, 11, 1'b0);
        // R3 blank check failure at address 5
        run_job(1, 5, 0, -1, 1'b0, 5, 22, 1'b0);
        // R8 bad write at address 9 caught in verify
        run_job(2, 9, 1, -1, 1'b0, 9, 33, 1'b0);
        // R8 second image stream differs at address 3
        run_job(0, 0, 0, 3, 1'b0, 3, 44, 1'b0);
        // R9 clean job after failures sets pass again
        run_job(0, 0, 0, -1, 1'b1, 0, 55, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule